// File: doc/BRIEF.md
# Dual-Rate Serializer with Loopback

The block turns 20-bit parallel words into a serial bit stream. Each word holds two 10-bit encoded characters. A one-cycle word strobe, taken on the word clock edge, captures the word into a holding register. The shifter then sends it starting from bit 0 and ending with bit 19. A bit-rate enable, `tick_i`, paces the shifter. At full speed every tick moves one bit. At half speed every second tick moves one bit, so a word takes 20 or 40 ticks. The next word is taken as soon as the last bit of the current one has been shown, so there is no gap between words.

A wrap control moves the serial stream onto an internal loopback output that feeds the receiver. While wrap is set, the line pair is held with its true side high and its complement side low. A small decode stage produces separate transmit and receive full-speed selects from three inputs: a mode input, a transmit rate input and a receive rate input. With the mode input low, the transmit rate input alone sets both selects.

Top module: `dual_rate_ser`

## Requirements
- R1: A word present on `word_i` while `word_stb_i` is high at a rising clock edge is held. It is loaded into the shifter on the next serial step, and a step is taken on that same edge only if the shifter is idle or has just shown bit 19.
- R2: After a load, the serial bit equals word bit 0. Each later step advances one bit position, and bit 19 is the last one shown.
- R3: With the transmit select at full speed, every edge with `tick_i` high is a serial step, so one word spans 20 ticks.
- R4: With the transmit select at half speed, a serial step is taken on every second edge with `tick_i` high, counted from reset. The first step is therefore on the second tick, and one word spans 40 ticks.
- R5: When a new word is held by the step that follows bit 19, that word's bit 0 follows bit 19 directly, with no idle bit between them.
- R6: When no word is held at that step, the serial bit returns to idle (logic 1) and stays there until a word is loaded.
- R7: An edge with `tick_i` low leaves the serial bit and the position within the word unchanged.
- R8: With `wrap_i` high, `tx_p_o` is 1, `tx_n_o` is 0, and `loop_o` carries the serial bit.
- R9: With `wrap_i` low, `tx_p_o` carries the serial bit, `tx_n_o` carries its complement, and `loop_o` is held at 1.
- R10: With `sep_rate_i` = 0, both `tx_full_o` and `rx_full_o` equal `tx_rate_i` (1 = full, 0 = half), and `rx_rate_i` has no effect.
- R11: With `sep_rate_i` = 1, `tx_full_o` equals `tx_rate_i` and `rx_full_o` equals `rx_rate_i`.
- R12: While `rst_ni` is low, and after it rises until the first load, the shifter is idle: `tx_p_o` = 1, `tx_n_o` = 0, `loop_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Bit-rate enable |
| word_stb_i | input | 1 | Word clock edge strobe; captures `word_i` |
| word_i | input | 20 | Parallel word, bit 0 sent first |
| wrap_i | input | 1 | 1 = loop stream internally, hold line idle |
| sep_rate_i | input | 1 | 1 = independent transmit and receive rates |
| tx_rate_i | input | 1 | Transmit rate, 1 = full |
| rx_rate_i | input | 1 | Receive rate, 1 = full; used only when `sep_rate_i` = 1 |
| tx_p_o | output | 1 | Line output, true side |
| tx_n_o | output | 1 | Line output, complement side |
| loop_o | output | 1 | Loopback serial data toward the receiver |
| tx_full_o | output | 1 | Decoded transmit full-speed select |
| rx_full_o | output | 1 | Decoded receive full-speed select |

## Verification
The serial outputs change on the same clock edge as the step that causes the change, with no register in between. A load therefore shows bit 0 right after the edge that loads it. The bench keeps its own count of the steps it has caused: one per tick at full speed, one per second tick at half speed. From that count it derives the expected word and bit position, and it compares the outputs at every falling edge, half a period after the step. The rate selects are combinational, so they are checked shortly after each input change.

// File: rtl/dual_ser_pkg.sv
package dual_ser_pkg;
  localparam int unsigned WORD_W_DEF = 20;
  localparam int unsigned HALF_DIV_DEF = 2;

  typedef enum logic {
    RATE_HALF = 1'b0,
    RATE_FULL = 1'b1
  } rate_e;
endpackage

// File: rtl/ser_rate_decode.sv
module ser_rate_decode
  import dual_ser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sep_rate_i,
  input  logic tx_rate_i,
  input  logic rx_rate_i,
  output logic tx_full_o,
  output logic rx_full_o
);
  rate_e tx_sel, rx_sel;

  always_comb begin
    tx_sel = rate_e'(tx_rate_i);
    rx_sel = sep_rate_i ? rate_e'(rx_rate_i) : tx_sel;
  end

  assign tx_full_o = (tx_sel == RATE_FULL);
  assign rx_full_o = (rx_sel == RATE_FULL);

  AST_RATES_TIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sep_rate_i |-> (rx_full_o == tx_rate_i)); // R10
  AST_RATES_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sep_rate_i |-> (rx_full_o == rx_rate_i) && (tx_full_o == tx_rate_i)); // R11
endmodule

// File: rtl/ser_pacer.sv
module ser_pacer #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic full_i,
  output logic step_o
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (full_i) begin
      div_q <= '0;
    end else if (tick_i) begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign step_o = tick_i & (full_i | (div_q == DIV_LAST));

  AST_HALF_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_i && step_o) |=> !step_o); // R4
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !step_o); // R7
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              word_stb_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_bit_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q, shreg_q;
  logic              hold_vld_q, active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              at_end, load;

  assign at_end = !active_q || (cnt_q == CNT_LAST);
  assign load   = step_i && at_end && hold_vld_q;

  // holding register: a fresh strobe wins over consumption on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      if (load) hold_vld_q <= 1'b0;
      if (word_stb_i) begin
        hold_q     <= word_i;
        hold_vld_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (step_i) begin
      if (at_end) begin
        cnt_q    <= '0;
        active_q <= hold_vld_q;
        shreg_q  <= hold_vld_q ? hold_q : '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
      end
    end
  end

  assign ser_bit_o = active_q ? shreg_q[0] : 1'b1;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(shreg_q) && $stable(cnt_q) && $stable(active_q)); // R7
  AST_GAPLESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && active_q && cnt_q == CNT_LAST && hold_vld_q) |=> active_q && cnt_q == '0); // R5
  AST_UNDERRUN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && at_end && !hold_vld_q) |=> ser_bit_o); // R6
  AST_LOAD_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> ser_bit_o == $past(hold_q[0])); // R1
endmodule

// File: rtl/ser_line_mux.sv
module ser_line_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic ser_bit_i,
  output logic tx_p_o,
  output logic tx_n_o,
  output logic loop_o
);
  always_comb begin
    if (wrap_i) begin
      tx_p_o = 1'b1;
      tx_n_o = 1'b0;
      loop_o = ser_bit_i;
    end else begin
      tx_p_o = ser_bit_i;
      tx_n_o = ~ser_bit_i;
      loop_o = 1'b1;
    end
  end

  AST_LINE_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |-> (tx_p_o != tx_n_o) && loop_o); // R9
endmodule

// File: rtl/dual_rate_ser.sv
module dual_rate_ser
  import dual_ser_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned HALF_DIV = HALF_DIV_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              word_stb_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wrap_i,
  input  logic              sep_rate_i,
  input  logic              tx_rate_i,
  input  logic              rx_rate_i,
  output logic              tx_p_o,
  output logic              tx_n_o,
  output logic              loop_o,
  output logic              tx_full_o,
  output logic              rx_full_o
);
  logic step, ser_bit;

  ser_rate_decode u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sep_rate_i (sep_rate_i),
    .tx_rate_i  (tx_rate_i),
    .rx_rate_i  (rx_rate_i),
    .tx_full_o  (tx_full_o),
    .rx_full_o  (rx_full_o)
  );

  ser_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .full_i (tx_full_o),
    .step_o (step)
  );

  ser_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .word_stb_i (word_stb_i),
    .word_i     (word_i),
    .ser_bit_o  (ser_bit)
  );

  ser_line_mux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap_i),
    .ser_bit_i (ser_bit),
    .tx_p_o    (tx_p_o),
    .tx_n_o    (tx_n_o),
    .loop_o    (loop_o)
  );

  AST_WRAP_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> tx_p_o && !tx_n_o && (loop_o == ser_bit)); // R8
  AST_FULL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && tx_full_o) |-> step); // R3
endmodule

// File: tb/tb_dual_rate_ser.sv
module tb_dual_rate_ser;
  localparam time CLK_PERIOD = 10ns;
  localparam int WW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, stb = 1'b0, wrap = 1'b0;
  logic sep = 1'b0, txr = 1'b1, rxr = 1'b1;
  logic [WW-1:0] word = '0;
  logic tx_p, tx_n, lp, txf, rxf;

  int checks = 0;
  int errors = 0;

  logic [WW-1:0] wl [4] = '{20'hA5C3E, 20'h3B07D, 20'hFFFFF, 20'h00000};

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rate_ser dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .word_stb_i(stb), .word_i(word),
    .wrap_i(wrap), .sep_rate_i(sep), .tx_rate_i(txr), .rx_rate_i(rxr),
    .tx_p_o(tx_p), .tx_n_o(tx_n), .loop_o(lp), .tx_full_o(txf), .rx_full_o(rxf)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %b exp %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic full, input logic wr);
    rst_n = 1'b0; tick = 1'b0; stb = 1'b0;
    wrap = wr; sep = 1'b0; txr = full; rxr = ~full;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R12: idle line during and right after reset
  task automatic t_reset_state();
    rst_n = 1'b0; wrap = 1'b0; tick = 1'b1; stb = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_p && !tx_n && lp, "R12", "in reset", {tx_p, tx_n, lp}, 3'b101);
    rst_n = 1'b1; tick = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_p && !tx_n && lp, "R12", "after reset", {tx_p, tx_n, lp}, 3'b101);
    tick = 1'b0;
  endtask

  // R10 R11: rate decode over all input combinations
  task automatic t_decode();
    for (int i = 0; i < 8; i++) begin
      logic es, et, er;
      {sep, txr, rxr} = 3'(i);
      #1;
      et = txr;
      er = sep ? rxr : txr;
      chk(txf == et && rxf == er, sep ? "R11" : "R10", "rate sel",
          {1'b0, txf, rxf}, {1'b0, et, er});
    end
  endtask

  // Streams nw words; steps counted by the bench (1 per tick full, 1 per 2 ticks half).
  task automatic run_stream(input logic full, input logic wr, input int nw,
                            input int stall_at, input int stall_len, input string tag);
    int steps = 0, ticks = 0, next_w = 1, span;
    logic eb;
    do_reset(full, wr);
    span = nw * WW * (full ? 1 : 2) + 3 * WW + stall_len;
    for (int c = 0; c <= span; c++) begin
      logic tk;
      @(negedge clk);
      if (steps == 0 || (steps - 1) / WW >= nw) eb = 1'b1;
      else eb = wl[(steps - 1) / WW][(steps - 1) % WW];
      if (wr)
        chk(tx_p && !tx_n && lp == eb, tag, "wrap out", {tx_p, tx_n, lp}, {2'b10, eb});
      else
        chk(tx_p == eb && tx_n == ~eb && lp, tag, "line out", {tx_p, tx_n, lp}, {eb, ~eb, 1'b1});
      stb = 1'b0;
      if (c == 0) begin
        stb = 1'b1; word = wl[0];
      end else if (next_w < nw && steps >= WW * (next_w - 1) + 1) begin
        stb = 1'b1; word = wl[next_w]; next_w++;
      end
      tk = (c >= 1) && !(c >= stall_at && c < stall_at + stall_len);
      tick = tk;
      if (tk) begin
        ticks++;
        if (full || (ticks % 2 == 0)) steps++;
      end
    end
    tick = 1'b0; stb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_decode();
    run_stream(1'b1, 1'b0, 4, -1, 0, "R1 R2 R3 R5 R9");   // full speed, gapless
    run_stream(1'b0, 1'b0, 3, -1, 0, "R4 R5 R6");         // half speed, then underrun
    run_stream(1'b1, 1'b1, 2, -1, 0, "R8");               // wrap: line idle, loop carries data
    run_stream(1'b0, 1'b1, 2, -1, 0, "R8 R4");
    run_stream(1'b1, 1'b0, 2, 8, 5, "R7");                // tick stall mid-word
    run_stream(1'b0, 1'b0, 2, 11, 3, "R7 R4");
    run_stream(1'b1, 1'b0, 1, -1, 0, "R6 R12");           // single word then idle
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule